// File: doc/BRIEF.md
# Cache Block Zeroing Engine

This engine clears one naturally aligned block of memory for each request it accepts. A request carries a 64-bit address, a block-size code and the result of address translation: a memory-type tag and a translation-abort flag. The address may point anywhere inside the block. The engine masks its low bits to find the block base. It then writes zero to every byte of the block as a run of full-width write beats over a simple valid/ready write port.

The engine refuses a request without touching memory in three cases: the size code is out of range, translation has already aborted, or the target is device memory. In each case it reports a fault. A write beat can also come back with an error, and that stops the run at the beat where the error arrived. Every request ends with a single one-cycle pulse, either done or fault. A fault comes with a syndrome: a fault code, a cache-maintenance bit that is always reported as 0, and the faulting address.

Top module: `blkzero_engine`

## Requirements
- R1: `req_ready` is 1 only while the engine is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. A `req_valid` raised while the engine is busy has no effect on the beats in progress.
- R2: The block size in bytes is N = 4 << `req_bs`. A size below the bus width (8 bytes) or above 2048 bytes is refused with fault code 3, and no beat is issued.
- R3: Beats go to the block base (`req_addr` with its low log2(N) bits cleared), then base+8, base+16 and so on in ascending order. There are exactly N/8 beats.
- R4: Every beat has all 8 strobe bits set and data equal to zero.
- R5: While `wr_valid` is 1 and `wr_ready` is 0, the beat stays offered with the same address.
- R6: Memory-type encoding: `req_mtype[1]`=1 marks device memory (2'b10, 2'b11). Device memory is refused with fault code 1 (alignment) and no beat is issued. Normal memory, 2'b00 non-cacheable and 2'b01 cacheable, is zeroed in the same way.
- R7: A request with `req_xlat_abort`=1 is refused with fault code 2 (abort) and no beat is issued. When several refusal causes are present, the priority is size (code 3), then translation abort (code 2), then device (code 1).
- R8: If `wr_err` is 1 on a beat that is accepted, the run stops. The engine reports fault code 2 with `fault_addr` equal to that beat's address and issues no further beat.
- R9: Every request ends with exactly one pulse of `done` or of `fault`, one cycle long. The pulse comes in the cycle after the last beat is accepted, or in the cycle after the request is taken if the request is refused. With every fault, `fault_cm` is 0. For refused requests, `fault_addr` is `req_addr` exactly as supplied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_addr | input | 64 | Any address inside the target block |
| req_bs | input | 4 | Block-size code, N = 4 << code bytes |
| req_mtype | input | 2 | Memory type from translation |
| req_xlat_abort | input | 1 | Translation aborted for this request |
| wr_valid | output | 1 | Write beat offered |
| wr_ready | input | 1 | Memory accepts the beat |
| wr_addr | output | 64 | Beat byte address |
| wr_data | output | 64 | Beat data (zero) |
| wr_strb | output | 8 | Byte strobes (all set) |
| wr_err | input | 1 | Error on the beat accepted this cycle |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | One-cycle fault pulse |
| fault_code | output | 2 | 1 alignment, 2 abort, 3 illegal size |
| fault_cm | output | 1 | Cache-maintenance syndrome bit (0) |
| fault_addr | output | 64 | Faulting address |

## Verification
The bench sweeps every size code against several unaligned addresses, including one near the top of the address space. A design that masked the base with the wrong width would then start at a shifted address or wrap. The bench also runs two ready patterns, so a design that advanced without a handshake would skip addresses. The boundary size codes 0, 1, 9 and 10 catch an off-by-one in the legal range. Refusals are combined to test their order of priority. Write errors are injected on the first, a middle and the last beat, so a design that kept writing after an error, or reported the wrong beat's address, is caught. A request raised while the engine is busy must leave the running beat sequence untouched.

// File: rtl/blkzero_pkg.sv
package blkzero_pkg;
  typedef enum logic [1:0] {
    FC_NONE  = 2'd0,
    FC_ALIGN = 2'd1,
    FC_ABORT = 2'd2,
    FC_SIZE  = 2'd3
  } fault_code_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_RESP  = 2'd2
  } zero_state_e;

  function automatic logic is_device(input logic [1:0] mtype);
    return mtype[1];
  endfunction
endpackage

// File: rtl/blkzero_decode.sv
module blkzero_decode
  import blkzero_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int BS_W       = 4,
  parameter int BEAT_BYTES = 8,
  parameter int MAX_BYTES  = 2048,
  parameter int CNT_W      = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BS_W-1:0]   bs_i,
  input  logic [1:0]        mtype_i,
  input  logic              xlat_abort_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [CNT_W-1:0]  last_o,
  output fault_code_e       code_o
);
  localparam int SZ_W    = (1 << BS_W) + 3;
  localparam int BEAT_SH = $clog2(BEAT_BYTES);

  logic [SZ_W-1:0] size_b;
  logic [SZ_W-1:0] beats;
  logic            size_bad;

  always_comb begin
    size_b   = SZ_W'(4) << bs_i;
    beats    = size_b >> BEAT_SH;
    size_bad = (size_b < SZ_W'(BEAT_BYTES)) || (size_b > SZ_W'(MAX_BYTES));
    base_o   = addr_i & ~ADDR_W'(size_b - SZ_W'(1));
    last_o   = CNT_W'(beats - SZ_W'(1));
    // refusal priority: size, then translation abort, then device type
    if (size_bad)                code_o = FC_SIZE;
    else if (xlat_abort_i)       code_o = FC_ABORT;
    else if (is_device(mtype_i)) code_o = FC_ALIGN;
    else                         code_o = FC_NONE;
  end
endmodule

// File: rtl/blkzero_seq.sv
module blkzero_seq
  import blkzero_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int BEAT_BYTES = 8,
  parameter int CNT_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  fault_code_e       code_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]  last_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              wr_ready_i,
  input  logic              wr_err_i,
  output logic              idle_o,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              done_o,
  output logic              fault_o,
  output fault_code_e       fault_code_o,
  output logic [ADDR_W-1:0] fault_addr_o
);
  zero_state_e       state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic              done_q, done_d, fault_q, fault_d;
  fault_code_e       code_q, code_d;
  logic [ADDR_W-1:0] faddr_q, faddr_d;
  logic              beat_en, synd_en;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    left_d  = left_q;
    done_d  = 1'b0;
    fault_d = 1'b0;
    code_d  = code_q;
    faddr_d = faddr_q;
    beat_en = 1'b0;
    synd_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (code_i != FC_NONE) begin
            state_d = ST_RESP;
            fault_d = 1'b1;
            code_d  = code_i;
            faddr_d = req_addr_i;
            synd_en = 1'b1;
          end else begin
            state_d = ST_WRITE;
            addr_d  = base_i;
            left_d  = last_i;
            beat_en = 1'b1;
          end
        end
      end
      ST_WRITE: begin
        if (wr_ready_i) begin
          if (wr_err_i) begin
            state_d = ST_RESP;
            fault_d = 1'b1;
            code_d  = FC_ABORT;
            faddr_d = addr_q;
            synd_en = 1'b1;
          end else if (left_q == '0) begin
            state_d = ST_RESP;
            done_d  = 1'b1;
          end else begin
            addr_d  = addr_q + ADDR_W'(BEAT_BYTES);
            left_d  = left_q - CNT_W'(1);
            beat_en = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      addr_q  <= '0;
      left_q  <= '0;
      code_q  <= FC_NONE;
      faddr_q <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      fault_q <= fault_d;
      if (beat_en) begin
        addr_q <= addr_d;
        left_q <= left_d;
      end
      if (synd_en) begin
        code_q  <= code_d;
        faddr_q <= faddr_d;
      end
    end
  end

  assign idle_o       = (state_q == ST_IDLE);
  assign wr_valid_o   = (state_q == ST_WRITE);
  assign wr_addr_o    = addr_q;
  assign done_o       = done_q;
  assign fault_o      = fault_q;
  assign fault_code_o = code_q;
  assign fault_addr_o = faddr_q;
endmodule

// File: rtl/blkzero_engine.sv
module blkzero_engine
  import blkzero_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int DATA_W    = 64,
  parameter int BS_W      = 4,
  parameter int MAX_BYTES = 2048
) (
  input  logic                 clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [BS_W-1:0]     req_bs,
  input  logic [1:0]          req_mtype,
  input  logic                req_xlat_abort,
  output logic                wr_valid,
  input  logic                wr_ready,
  output logic [ADDR_W-1:0]   wr_addr,
  output logic [DATA_W-1:0]   wr_data,
  output logic [DATA_W/8-1:0] wr_strb,
  input  logic                wr_err,
  output logic                done,
  output logic                fault,
  output logic [1:0]          fault_code,
  output logic                fault_cm,
  output logic [ADDR_W-1:0]   fault_addr
);
  localparam int BEAT_BYTES = DATA_W / 8;
  localparam int MAX_BEATS  = MAX_BYTES / BEAT_BYTES;
  localparam int CNT_W      = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1;

  logic [ADDR_W-1:0] dec_base;
  logic [CNT_W-1:0]  dec_last;
  fault_code_e       dec_code;
  fault_code_e       seq_code;
  logic              idle;

  blkzero_decode #(
    .ADDR_W(ADDR_W), .BS_W(BS_W), .BEAT_BYTES(BEAT_BYTES),
    .MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)
  ) u_decode (
    .addr_i      (req_addr),
    .bs_i        (req_bs),
    .mtype_i     (req_mtype),
    .xlat_abort_i(req_xlat_abort),
    .base_o      (dec_base),
    .last_o      (dec_last),
    .code_o      (dec_code)
  );

  blkzero_seq #(
    .ADDR_W(ADDR_W), .BEAT_BYTES(BEAT_BYTES), .CNT_W(CNT_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (req_valid & idle),
    .code_i      (dec_code),
    .base_i      (dec_base),
    .last_i      (dec_last),
    .req_addr_i  (req_addr),
    .wr_ready_i  (wr_ready),
    .wr_err_i    (wr_err),
    .idle_o      (idle),
    .wr_valid_o  (wr_valid),
    .wr_addr_o   (wr_addr),
    .done_o      (done),
    .fault_o     (fault),
    .fault_code_o(seq_code),
    .fault_addr_o(fault_addr)
  );

  assign req_ready  = idle;
  assign wr_data    = '0;
  assign wr_strb    = '1;
  assign fault_code = seq_code;
  assign fault_cm   = 1'b0;
endmodule

// File: rtl/blkzero_chk.sv
module blkzero_chk #(
  parameter int ADDR_W  = 64,
  parameter int BEAT_SH = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              done,
  input logic              fault
);
  // R1
  busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !req_ready);

  // R5
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr)));

  // R3
  beat_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr[BEAT_SH-1:0] == '0));

  // R9
  single_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !fault);

  // R8
  end_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |-> !wr_valid);
endmodule

bind blkzero_engine blkzero_chk #(
  .ADDR_W (ADDR_W),
  .BEAT_SH($clog2(DATA_W / 8))
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_ready(req_ready),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .wr_addr  (wr_addr),
  .done     (done),
  .fault    (fault)
);

// File: tb/test_blkzero_engine.sv
`timescale 1ns/1ps
module test_blkzero_engine;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [63:0] req_addr;
  logic [3:0]  req_bs;
  logic [1:0]  req_mtype;
  logic        req_xlat_abort;
  logic        wr_valid;
  logic        wr_ready;
  logic [63:0] wr_addr;
  logic [63:0] wr_data;
  logic [7:0]  wr_strb;
  logic        wr_err;
  logic        done;
  logic        fault;
  logic [1:0]  fault_code;
  logic        fault_cm;
  logic [63:0] fault_addr;

  int checks = 0;
  int errors = 0;

  blkzero_engine i_blkzero_engine (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_bs(req_bs), .req_mtype(req_mtype), .req_xlat_abort(req_xlat_abort),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_strb(wr_strb), .wr_err(wr_err),
    .done(done), .fault(fault), .fault_code(fault_code),
    .fault_cm(fault_cm), .fault_addr(fault_addr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one request from offer to the cycle after its end pulse
  task automatic run_req(input logic [63:0] a, input logic [1:0] mt,
                         input logic [3:0] bs, input bit xab,
                         input int err_beat, input int pat, input bit spam);
    int          n;
    int          nb;
    int          seen;
    int          guard;
    int          exp_code;
    bit          legal;
    bit          exp_done;
    bit          busy_bad;
    bit          addr_bad;
    bit          data_bad;
    logic [63:0] base;
    logic [63:0] exp_faddr;
    logic [63:0] bad_act;
    logic [63:0] bad_exp;
    bit          rdy;

    n     = 4 << bs;
    legal = (n >= 8) && (n <= 2048);
    base  = a & ~(64'(n) - 64'd1);
    exp_done = 1'b0;
    exp_faddr = a;
    nb = 0;
    if (!legal)       exp_code = 3;
    else if (xab)     exp_code = 2;
    else if (mt[1])   exp_code = 1;
    else if (err_beat >= 0 && err_beat < n / 8) begin
      exp_code  = 2;
      exp_faddr = base + 64'(8 * err_beat);
      nb        = err_beat + 1;
    end else begin
      exp_code = 0;
      exp_done = 1'b1;
      nb       = n / 8;
    end

    @(negedge clk);
    check(req_ready == 1'b1, "R1", "ready before request", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_addr = a; req_bs = bs; req_mtype = mt; req_xlat_abort = xab;
    @(negedge clk);
    req_valid = spam;
    req_addr  = ~a; req_bs = 4'd9; req_mtype = 2'b00; req_xlat_abort = 1'b0;

    seen = 0; guard = 0; busy_bad = 0; addr_bad = 0; data_bad = 0;
    bad_act = '0; bad_exp = '0;
    while (!(done || fault) && guard < 5000) begin
      if (req_ready) busy_bad = 1;
      if (wr_valid) begin
        if (!addr_bad && wr_addr != base + 64'(8 * seen)) begin
          addr_bad = 1; bad_act = wr_addr; bad_exp = base + 64'(8 * seen);
        end
        if (wr_data != '0 || wr_strb != 8'hFF) data_bad = 1;
        rdy = (pat == 0) ? 1'b1 : ((guard % 3) != 1);
        wr_ready = rdy;
        wr_err   = rdy && (seen == err_beat);
        if (rdy) seen++;
      end else begin
        wr_ready = 1'b0; wr_err = 1'b0;
      end
      @(negedge clk);
      guard++;
    end
    wr_ready = 1'b0; wr_err = 1'b0; req_valid = 1'b0;

    check(!busy_bad, "R1", "ready low while busy", 64'(busy_bad), 64'd0);
    check(!addr_bad, "R3", "beat address order", bad_act, bad_exp);
    check(!data_bad, "R4", "zero data full strobes", 64'(data_bad), 64'd0);
    check(seen == nb, "R3", "beat count", 64'(seen), 64'(nb));
    check(done == exp_done && fault == !exp_done, "R9", "end pulse kind",
          {62'd0, done, fault}, {62'd0, exp_done, !exp_done});
    if (!exp_done) begin
      check(fault_code == 2'(exp_code), (exp_code == 3) ? "R2" :
            (exp_code == 1) ? "R6" : ((nb > 0) ? "R8" : "R7"),
            "fault code", 64'(fault_code), 64'(exp_code));
      check(fault_addr == exp_faddr, (nb > 0) ? "R8" : "R9", "fault address",
            fault_addr, exp_faddr);
      check(fault_cm == 1'b0, "R9", "syndrome cm bit", 64'(fault_cm), 64'd0);
    end
    @(negedge clk);
    check(!done && !fault, "R9", "pulse one cycle", {62'd0, done, fault}, 64'd0);
    check(req_ready && !wr_valid, "R8", "idle after end", {62'd0, req_ready, wr_valid}, 64'd2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL all watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  logic [63:0] addrs [3];

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_bs = '0; req_mtype = '0;
    req_xlat_abort = 1'b0; wr_ready = 1'b0; wr_err = 1'b0;
    addrs[0] = 64'h0000_1234_5678_9ABF;
    addrs[1] = 64'hFFFF_FFFF_FFFF_FFF3;
    addrs[2] = 64'h0;
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1 && !wr_valid && !done && !fault, "R1", "reset state",
          {60'd0, req_ready, wr_valid, done, fault}, 64'h8);
    rst_n = 1'b1;

    // R2 R3 R4 R5 R6: all size codes, unaligned addresses, two ready patterns
    for (int bs = 0; bs < 16; bs++)
      for (int ai = 0; ai < 3; ai++)
        for (int p = 0; p < 2; p++)
          run_req(addrs[ai], {1'b0, 1'(bs)}, 4'(bs), 1'b0, -1, p, 1'b0);

    // R6: device types refused
    run_req(64'h0000_0000_0000_4321, 2'b10, 4'd3, 1'b0, -1, 0, 1'b0);
    run_req(64'h0000_0000_0000_4321, 2'b11, 4'd9, 1'b0, -1, 1, 1'b0);
    // R7: translation abort and refusal priority
    run_req(64'h0000_0000_0000_0805, 2'b00, 4'd4, 1'b1, -1, 0, 1'b0);
    run_req(64'h0000_0000_0000_0805, 2'b11, 4'd4, 1'b1, -1, 0, 1'b0);
    run_req(64'h0000_0000_0000_0805, 2'b11, 4'd0, 1'b1, -1, 0, 1'b0);
    run_req(64'h0000_0000_0000_0805, 2'b10, 4'd12, 1'b0, -1, 0, 1'b0);
    // R8: write error on first, middle and last beat
    run_req(64'h0000_0000_0001_0047, 2'b00, 4'd4, 1'b0, 0, 0, 1'b0);
    run_req(64'h0000_0000_0001_0047, 2'b01, 4'd4, 1'b0, 3, 1, 1'b0);
    run_req(64'h0000_0000_0001_0047, 2'b00, 4'd4, 1'b0, 7, 1, 1'b0);
    run_req(64'h0000_0000_0001_0047, 2'b00, 4'd9, 1'b0, 255, 0, 1'b0);
    // R1: request raised while busy is ignored
    run_req(64'h0000_0000_0002_0101, 2'b01, 4'd5, 1'b0, -1, 1, 1'b1);
    run_req(64'h0000_0000_0002_0101, 2'b00, 4'd3, 1'b0, 2, 0, 1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule